// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the decode stage of a core whose set of privilege modes is chosen at build or boot time: machine only, machine plus user, either of those with user-level trap handling, or the full machine, supervisor and user arrangement. The decoder presents one classified operation per cycle. The operation is a user-level trap return, a supervisor trap return, an address-translation fence, a wait-for-interrupt, or a CSR access. The decoder also presents the current privilege level, the flags naming which optional modes exist, and the trap-wait and translation-trap status bits. The block answers one cycle later with an illegal-instruction flag, which the trap logic uses to raise an exception in place of executing the operation.

The block also cleans up the previous-privilege field of the machine status register on its way to a reader. An encoding that names a mode the core lacks, or the reserved encoding, is replaced by the nearest mode that is present. For a CSR access, the decoder supplies the extension letters that the register needs as a one-hot-per-letter mask. The block compares that mask with the extensions the core has: a fixed base set, plus the supervisor, user and user-trap letters that the mode flags switch on.

Top module: `priv_legal_chk`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `illegal_o` is 0 and `mpp_o` is 2'b11 (machine).
- R2: A user trap return (`op_kind` 3'd1) is flagged illegal exactly when `has_n` is 0.
- R3: A supervisor trap return (`op_kind` 3'd2) is flagged illegal exactly when `has_s` is 0.
- R4: An address-translation fence (`op_kind` 3'd3) is illegal when `has_s` is 0. When `has_s` is 1 it is illegal at user privilege (2'b00), or at supervisor privilege (2'b01) with `tvm_bit` set. It is legal otherwise.
- R5: A wait-for-interrupt (`op_kind` 3'd4) is illegal only when `has_s` is 1 and either the privilege is user, or the privilege is supervisor with `tw_bit` set. With `has_s` 0 it is legal at every privilege.
- R6: A CSR access (`op_kind` 3'd5) is illegal when any bit set in `csr_req_ext` is absent from the implemented extension vector. That vector holds `BASE_EXT`, with bit 13 set by `has_n`, bit 18 by `has_s` and bit 20 by `has_u` (bit k stands for the k-th letter, A = bit 0).
- R7: `mpp_o` maps `mpp_in` as follows. User (2'b00) reads as user if `has_u` is 1, otherwise as machine (2'b11). Supervisor (2'b01) reads as supervisor if `has_s` is 1, else as user if `has_u` is 1, else as machine. Machine stays machine. The reserved value 2'b10 reads as user if `has_u` is 1, else as machine.
- R8: `illegal_o` reflects the operation presented with `op_valid` high one clock edge earlier. It is 0 after a cycle with `op_valid` low, or with `op_kind` 3'd0, 3'd6 or 3'd7.
- R9: `mpp_o` reflects `mpp_in` and the mode flags one clock edge earlier, and never shows the reserved value 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | 0 none, 1 user return, 2 supervisor return, 3 translation fence, 4 wait-for-interrupt, 5 CSR access |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| has_s | input | 1 | Supervisor mode implemented |
| has_u | input | 1 | User mode implemented |
| has_n | input | 1 | User-level trap handling implemented |
| tw_bit | input | 1 | Trap-wait status bit |
| tvm_bit | input | 1 | Translation-trap status bit |
| csr_req_ext | input | EXT_W | Extension letters required by the accessed CSR |
| mpp_in | input | 2 | Raw previous-privilege field |
| illegal_o | output | 1 | Registered illegal-instruction flag |
| mpp_o | output | 2 | Registered legalised previous-privilege value |

## Verification
On every cycle, the assertions check the verdicts that do not depend on privilege. They cover the return instructions against their mode flags, and fences and waits on a core without a supervisor mode. They also check that an empty extension request never traps, that a flag is only raised after a valid operation, and that the status field never shows the reserved code or a mode the core lacks. Only the bench's scenarios can show the privilege-dependent cases of the fence and the wait. The same holds for the exact letter matching of CSR requests against each of the five mode sets, the full previous-privilege table, and the reset values.

// File: rtl/priv_legal_pkg.sv
package priv_legal_pkg;

  typedef enum logic [2:0] {
    OPK_NONE   = 3'd0,
    OPK_URET   = 3'd1,
    OPK_SRET   = 3'd2,
    OPK_SFENCE = 3'd3,
    OPK_WFI    = 3'd4,
    OPK_CSR    = 3'd5
  } op_kind_e;

  localparam logic [1:0] PRV_USER  = 2'b00;
  localparam logic [1:0] PRV_SUPER = 2'b01;
  localparam logic [1:0] PRV_RSVD  = 2'b10;
  localparam logic [1:0] PRV_MACH  = 2'b11;

  // letter positions in the extension vector (A = 0)
  localparam int unsigned LETTER_N = 13;
  localparam int unsigned LETTER_S = 18;
  localparam int unsigned LETTER_U = 20;

endpackage

// File: rtl/pl_ext_match.sv
module pl_ext_match #(
  parameter int unsigned    EXT_W    = 26,
  parameter logic [EXT_W-1:0] BASE_EXT = '0
) (
  input  logic             has_s,
  input  logic             has_u,
  input  logic             has_n,
  input  logic [EXT_W-1:0] req_ext,
  output logic             ext_miss
);
  import priv_legal_pkg::*;

  logic [EXT_W-1:0] have_ext;
  logic [EXT_W-1:0] lack;

  for (genvar k = 0; k < EXT_W; k++) begin : g_letter
    if (k == LETTER_N) begin : g_n
      assign have_ext[k] = BASE_EXT[k] | has_n;
    end else if (k == LETTER_S) begin : g_s
      assign have_ext[k] = BASE_EXT[k] | has_s;
    end else if (k == LETTER_U) begin : g_u
      assign have_ext[k] = BASE_EXT[k] | has_u;
    end else begin : g_fixed
      assign have_ext[k] = BASE_EXT[k];
    end
    assign lack[k] = req_ext[k] & ~have_ext[k];
  end

  assign ext_miss = |lack;

endmodule

// File: rtl/pl_op_rules.sv
module pl_op_rules (
  input  logic [2:0] op_code,
  input  logic [1:0] priv,
  input  logic       has_s,
  input  logic       has_n,
  input  logic       tw_bit,
  input  logic       tvm_bit,
  input  logic       ext_miss,
  output logic       op_bad
);
  import priv_legal_pkg::*;

  op_kind_e kind;
  logic     at_user;
  logic     at_super;

  assign kind     = op_kind_e'(op_code);
  assign at_user  = (priv == PRV_USER);
  assign at_super = (priv == PRV_SUPER);

  always_comb begin
    unique case (kind)
      OPK_URET:   op_bad = ~has_n;
      OPK_SRET:   op_bad = ~has_s;
      OPK_SFENCE: op_bad = ~has_s | at_user | (at_super & tvm_bit);
      OPK_WFI:    op_bad = has_s & (at_user | (at_super & tw_bit));
      OPK_CSR:    op_bad = ext_miss;
      default:    op_bad = 1'b0;
    endcase
  end

endmodule

// File: rtl/pl_mpp_fix.sv
module pl_mpp_fix (
  input  logic [1:0] raw_mpp,
  input  logic       has_s,
  input  logic       has_u,
  output logic [1:0] fixed_mpp
);
  import priv_legal_pkg::*;

  logic [1:0] lowest;

  assign lowest = has_u ? PRV_USER : PRV_MACH;

  always_comb begin
    unique case (raw_mpp)
      PRV_USER:  fixed_mpp = lowest;
      PRV_SUPER: fixed_mpp = has_s ? PRV_SUPER : lowest;
      PRV_MACH:  fixed_mpp = PRV_MACH;
      default:   fixed_mpp = lowest;
    endcase
  end

endmodule

// File: rtl/priv_legal_chk.sv
module priv_legal_chk #(
  parameter int unsigned      EXT_W    = 26,
  parameter logic [EXT_W-1:0] BASE_EXT = 26'h000112D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [1:0]       cur_priv,
  input  logic             has_s,
  input  logic             has_u,
  input  logic             has_n,
  input  logic             tw_bit,
  input  logic             tvm_bit,
  input  logic [EXT_W-1:0] csr_req_ext,
  input  logic [1:0]       mpp_in,
  output logic             illegal_o,
  output logic [1:0]       mpp_o
);
  import priv_legal_pkg::*;

  logic       ext_miss;
  logic       op_bad;
  logic [1:0] mpp_next;
  logic       illegal_q;
  logic [1:0] mpp_q;

  pl_ext_match #(
    .EXT_W    (EXT_W),
    .BASE_EXT (BASE_EXT)
  ) u_ext (
    .has_s    (has_s),
    .has_u    (has_u),
    .has_n    (has_n),
    .req_ext  (csr_req_ext),
    .ext_miss (ext_miss)
  );

  pl_op_rules u_rules (
    .op_code  (op_kind),
    .priv     (cur_priv),
    .has_s    (has_s),
    .has_n    (has_n),
    .tw_bit   (tw_bit),
    .tvm_bit  (tvm_bit),
    .ext_miss (ext_miss),
    .op_bad   (op_bad)
  );

  pl_mpp_fix u_mpp (
    .raw_mpp   (mpp_in),
    .has_s     (has_s),
    .has_u     (has_u),
    .fixed_mpp (mpp_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_q <= 1'b0;
      mpp_q     <= PRV_MACH;
    end else begin
      illegal_q <= op_valid & op_bad;
      mpp_q     <= mpp_next;
    end
  end

  assign illegal_o = illegal_q;
  assign mpp_o     = mpp_q;

endmodule

// File: rtl/priv_legal_sva.sv
module priv_legal_sva #(
  parameter int unsigned EXT_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       op_kind,
  input logic             has_s,
  input logic             has_u,
  input logic             has_n,
  input logic [EXT_W-1:0] csr_req_ext,
  input logic             illegal_o,
  input logic [1:0]       mpp_o
);

  // R8
  flag_needs_op_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(op_valid));

  // R2
  uret_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd1 && !has_n) |=> illegal_o);

  // R2
  uret_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd1 && has_n) |=> !illegal_o);

  // R3
  sret_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd2 && !has_s) |=> illegal_o);

  // R3
  sret_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd2 && has_s) |=> !illegal_o);

  // R4
  fence_nos_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd3 && !has_s) |=> illegal_o);

  // R5
  wfi_nos_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd4 && !has_s) |=> !illegal_o);

  // R6
  csr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd5 && csr_req_ext == '0) |=> !illegal_o);

  // R9
  mpp_no_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    mpp_o != 2'b10);

  // R7
  mpp_monly_chk: assert property (@(posedge clk) disable iff (rst)
    (!has_s && !has_u) |=> mpp_o == 2'b11);

  // R7
  mpp_nos_chk: assert property (@(posedge clk) disable iff (rst)
    !has_s |=> mpp_o != 2'b01);

endmodule

bind priv_legal_chk priv_legal_sva #(.EXT_W(EXT_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_kind     (op_kind),
  .has_s       (has_s),
  .has_u       (has_u),
  .has_n       (has_n),
  .csr_req_ext (csr_req_ext),
  .illegal_o   (illegal_o),
  .mpp_o       (mpp_o)
);

// File: tb/sim_priv_legal_chk.sv
module sim_priv_legal_chk;
  localparam int unsigned W = 26;
  localparam logic [W-1:0] BASE = 26'h000112D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [2:0]   op_kind = 3'd0;
  logic [1:0]   cur_priv = 2'b11;
  logic         has_s = 1'b0, has_u = 1'b0, has_n = 1'b0;
  logic         tw_bit = 1'b0, tvm_bit = 1'b0;
  logic [W-1:0] csr_req_ext = '0;
  logic [1:0]   mpp_in = 2'b00;
  logic         illegal_o;
  logic [1:0]   mpp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  priv_legal_chk #(.EXT_W(W), .BASE_EXT(BASE)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .cur_priv(cur_priv), .has_s(has_s), .has_u(has_u), .has_n(has_n),
    .tw_bit(tw_bit), .tvm_bit(tvm_bit), .csr_req_ext(csr_req_ext),
    .mpp_in(mpp_in), .illegal_o(illegal_o), .mpp_o(mpp_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mode sets: 0 M, 1 MU, 2 MNU, 3 MSU, 4 MNSU
  task automatic set_cfg(input int c);
    has_s = (c >= 3);
    has_u = (c >= 1);
    has_n = (c == 2) || (c == 4);
  endtask

  function automatic bit want_bad(input int op, input logic [1:0] p,
                                  input logic s, input logic u, input logic n,
                                  input logic tw, input logic tvm,
                                  input logic [W-1:0] req);
    logic [W-1:0] have;
    have = BASE;
    if (n) have[13] = 1'b1;
    if (s) have[18] = 1'b1;
    if (u) have[20] = 1'b1;
    case (op)
      1: return !n;
      2: return !s;
      3: return !s || p == 2'b00 || (p == 2'b01 && tvm);
      4: return s && (p == 2'b00 || (p == 2'b01 && tw));
      5: return (req & ~have) != '0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] want_mpp(input logic [1:0] r,
                                          input logic s, input logic u);
    logic [1:0] low;
    low = u ? 2'b00 : 2'b11;
    case (r)
      2'b00: return low;
      2'b01: return s ? 2'b01 : low;
      2'b11: return 2'b11;
      default: return low;
    endcase
  endfunction

  // present one op for one cycle, check the flag one edge later
  task automatic apply_op(input string tag, input int op, input logic [1:0] p,
                          input logic tw, input logic tvm, input logic [W-1:0] req);
    @(negedge clk);
    op_valid = 1'b1; op_kind = op[2:0]; cur_priv = p;
    tw_bit = tw; tvm_bit = tvm; csr_req_ext = req;
    @(negedge clk);
    check(tag, int'(illegal_o),
          int'(want_bad(op, p, has_s, has_u, has_n, tw, tvm, req)));
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op_valid = 1'b1; op_kind = 3'd2; has_s = 1'b0; mpp_in = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 illegal in reset", int'(illegal_o), 0);
    check("R1 mpp in reset", int'(mpp_o), 3);
    op_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 illegal after reset", int'(illegal_o), 0);
  endtask

  task automatic t_returns();
    for (int c = 0; c < 5; c++) begin
      set_cfg(c);
      apply_op("R2 uret", 1, 2'b11, 1'b0, 1'b0, '0);
      apply_op("R2 uret user", 1, 2'b00, 1'b0, 1'b0, '0);
      apply_op("R3 sret", 2, 2'b11, 1'b0, 1'b0, '0);
      apply_op("R3 sret super", 2, 2'b01, 1'b1, 1'b1, '0);
    end
  endtask

  task automatic t_fence_wfi();
    for (int c = 0; c < 5; c++) begin
      set_cfg(c);
      for (int pi = 0; pi < 3; pi++) begin
        logic [1:0] p;
        p = (pi == 2) ? 2'b11 : 2'(pi);
        for (int b = 0; b < 4; b++) begin
          apply_op("R4 sfence", 3, p, b[0], b[1], '0);
          apply_op("R5 wfi", 4, p, b[0], b[1], '0);
        end
      end
    end
  endtask

  task automatic t_csr();
    for (int c = 0; c < 5; c++) begin
      set_cfg(c);
      apply_op("R6 csr empty", 5, 2'b11, 1'b0, 1'b0, '0);
      apply_op("R6 csr base I", 5, 2'b11, 1'b0, 1'b0, W'(1) << 8);
      apply_op("R6 csr base FD", 5, 2'b11, 1'b0, 1'b0, W'(8) | W'(32));
      apply_op("R6 csr S", 5, 2'b11, 1'b0, 1'b0, W'(1) << 18);
      apply_op("R6 csr U", 5, 2'b11, 1'b0, 1'b0, W'(1) << 20);
      apply_op("R6 csr N", 5, 2'b11, 1'b0, 1'b0, W'(1) << 13);
      apply_op("R6 csr S+I", 5, 2'b01, 1'b0, 1'b0, (W'(1) << 18) | (W'(1) << 8));
      apply_op("R6 csr V absent", 5, 2'b11, 1'b0, 1'b0, W'(1) << 21);
    end
  endtask

  task automatic t_idle();
    set_cfg(0);
    // op_valid low with an op that would trap
    @(negedge clk);
    op_valid = 1'b0; op_kind = 3'd2; csr_req_ext = '0;
    @(negedge clk);
    check("R8 no valid", int'(illegal_o), 0);
    // valid with none and unused codes
    for (int k = 0; k < 3; k++) begin
      logic [2:0] code;
      code = (k == 0) ? 3'd0 : 3'(5 + k);
      @(negedge clk);
      op_valid = 1'b1; op_kind = code; csr_req_ext = W'(1) << 21;
      @(negedge clk);
      check("R8 inert code", int'(illegal_o), 0);
      op_valid = 1'b0;
    end
    // one-cycle latency: trapping op then drop valid
    @(negedge clk);
    op_valid = 1'b1; op_kind = 3'd1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R8 flag after one edge", int'(illegal_o), 1);
    @(negedge clk);
    check("R8 flag clears", int'(illegal_o), 0);
  endtask

  task automatic t_mpp();
    for (int c = 0; c < 5; c++) begin
      set_cfg(c);
      for (int r = 0; r < 4; r++) begin
        @(negedge clk);
        mpp_in = 2'(r);
        @(negedge clk);
        check("R7 mpp map", int'(mpp_o), int'(want_mpp(2'(r), has_s, has_u)));
      end
    end
    // latency: change input, output follows after one edge
    set_cfg(4);
    @(negedge clk);
    mpp_in = 2'b01;
    @(negedge clk);
    check("R9 mpp follows", int'(mpp_o), 1);
    set_cfg(1);
    #1;
    check("R9 mpp holds before edge", int'(mpp_o), 1);
    @(negedge clk);
    check("R9 mpp after edge", int'(mpp_o), 0);
  endtask

  initial begin
    t_reset();
    t_returns();
    t_fence_wfi();
    t_csr();
    t_idle();
    t_mpp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule